// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits inside a processor core, facing an external interrupt controller. It decides whether to take an offered interrupt. The decision uses the runtime priority kept in the low bits of the core's status word. A maskable request is taken only when its priority is strictly above that runtime priority. A non-maskable request is always taken. After reset the runtime priority is at its maximum, so only non-maskable requests can be taken until software has set up the stack pointer and lowered the priority with a status write.

Taking an interrupt runs a short sequence. The block saves the interrupted program counter and then the status word on a downward-growing stack, using a simple memory port. It then puts the request's priority into the status word and redirects the program counter to the vector number. A return command undoes this. It pops the status word, then the program counter, and restores both. No other registers are saved. The block also turns trap commands from the core into one-cycle trap requests towards the controller.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the status word holds all ones in its priority field (bits PRIO_W-1:0) and zeros elsewhere. The stack pointer is zero. While idle with no command, no maskable request is taken.
- R2: When the block is idle and no return, status-write or stack-pointer-write command is present, a maskable request (irq_nmi low) is taken only if irq_prio is strictly greater than the status priority field. irq_ack is combinational and is high in that same cycle.
- R3: When the same conditions hold, a request with irq_nmi high is taken whatever the status priority field holds.
- R4: In the cycle after acceptance, the PC sampled at acceptance is written at address sp-1. In the cycle after that, the status word is written at the new sp-1. The stack pointer drops by one after each write.
- R5: In the status-push cycle, pc_set is high and pc_new is the zero-extended vector number. From the next cycle, the status priority field holds the request's priority and the other status bits are unchanged.
- R6: A return command in an idle cycle reads address sp in that cycle, with memory data arriving one cycle later. In the next cycle the returned data is loaded into status and address sp+1 is read. In the cycle after that, pc_set is high with pc_new equal to the returned data. The stack pointer rises by one per word.
- R7: busy is high during entry and return sequences, and no request is acknowledged while busy.
- R8: In an idle cycle, status-write and stack-pointer-write commands load their values, and they block acceptance in that cycle. A return command takes precedence over both writes and over acceptance. While busy, both writes are ignored.
- R9: A trap command in a cycle makes trap_req high in the next cycle with trap_num equal to the command's number. Each command cycle gives one request cycle.
- R10: An entry performs exactly two memory writes and a return performs none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt offered, held until acknowledged |
| irq_nmi | input | 1 | Offered interrupt is non-maskable |
| irq_num | input | NUM_W | Vector number of offered interrupt |
| irq_prio | input | PRIO_W | Priority of offered interrupt |
| irq_ack | output | 1 | Request taken, one cycle |
| trap_cmd | input | 1 | Trap command from the core |
| trap_cmd_num | input | NUM_W | Trap number |
| trap_req | output | 1 | Trap request to the controller |
| trap_num | output | NUM_W | Trap number to the controller |
| reti_cmd | input | 1 | Return-from-interrupt command |
| sr_wr | input | 1 | Software status write |
| sr_wdata | input | DATA_W | Status write value |
| sp_wr | input | 1 | Stack pointer write |
| sp_wdata | input | ADDR_W | Stack pointer write value |
| cur_pc | input | DATA_W | Current program counter |
| pc_set | output | 1 | Redirect program counter |
| pc_new | output | DATA_W | New program counter value |
| sr | output | DATA_W | Status word |
| sp | output | ADDR_W | Stack pointer |
| busy | output | 1 | Entry or return sequence in progress |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | ADDR_W | Stack address |
| mem_wdata | output | DATA_W | Stack write data |
| mem_rdata | input | DATA_W | Stack read data, one cycle after mem_re |

## Verification
The bench builds the block with DATA_W 16, NUM_W 4, PRIO_W 3 and ADDR_W 8. The eight priority levels let single offers land below, equal to and above the runtime priority, including the all-ones reset value. The 8-bit stack pointer starts near zero, so three nested entries push across the wrap below address zero and the returns pop back across it. Non-maskable requests, status writes and trap commands are offered during busy sequences to probe the gating.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int NUM_W  = 4,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              irq_nmi,
  input  logic [NUM_W-1:0]  irq_num,
  input  logic [PRIO_W-1:0] irq_prio,
  output logic              irq_ack,
  input  logic              trap_cmd,
  input  logic [NUM_W-1:0]  trap_cmd_num,
  output logic              trap_req,
  output logic [NUM_W-1:0]  trap_num,
  input  logic              reti_cmd,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              sp_wr,
  input  logic [ADDR_W-1:0] sp_wdata,
  input  logic [DATA_W-1:0] cur_pc,
  output logic              pc_set,
  output logic [DATA_W-1:0] pc_new,
  output logic [DATA_W-1:0] sr,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}};
  localparam logic [DATA_W-1:0] SR_RST = {{(DATA_W-PRIO_W){1'b0}}, PRIO_MAX};
  localparam logic [ADDR_W-1:0] SP_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_PUSH_PC, S_PUSH_SR, S_POP_SR, S_POP_PC} st_t;

  st_t               st;
  logic [DATA_W-1:0] sr_q, pc_sv;
  logic [ADDR_W-1:0] sp_q;
  logic [NUM_W-1:0]  num_sv, trap_num_q;
  logic [PRIO_W-1:0] prio_sv;
  logic              trap_req_q;

  wire idle    = (st == S_IDLE);
  wire cmd_any = reti_cmd | sr_wr | sp_wr;
  wire above   = irq_prio > sr_q[PRIO_W-1:0];
  wire take    = idle & ~cmd_any & irq_req & (irq_nmi | above);
  wire [ADDR_W-1:0] sp_dn = sp_q - SP_ONE;
  wire [ADDR_W-1:0] sp_up = sp_q + SP_ONE;

  assign irq_ack   = take;
  assign busy      = ~idle;
  assign mem_we    = (st == S_PUSH_PC) | (st == S_PUSH_SR);
  assign mem_re    = (idle & reti_cmd) | (st == S_POP_SR);
  assign mem_addr  = mem_we ? sp_dn : sp_q;
  assign mem_wdata = (st == S_PUSH_PC) ? pc_sv : sr_q;
  assign pc_set    = (st == S_PUSH_SR) | (st == S_POP_PC);
  assign pc_new    = (st == S_POP_PC) ? mem_rdata : {{(DATA_W-NUM_W){1'b0}}, num_sv};
  assign sr        = sr_q;
  assign sp        = sp_q;
  assign trap_req  = trap_req_q;
  assign trap_num  = trap_num_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sr_q       <= SR_RST;
      sp_q       <= '0;
      pc_sv      <= '0;
      num_sv     <= '0;
      prio_sv    <= '0;
      trap_req_q <= 1'b0;
      trap_num_q <= '0;
    end else begin
      trap_req_q <= trap_cmd;
      trap_num_q <= trap_cmd_num;
      case (st)
        S_IDLE: begin
          if (reti_cmd) begin
            sp_q <= sp_up;
            st   <= S_POP_SR;
          end else begin
            if (sr_wr) sr_q <= sr_wdata;
            if (sp_wr) sp_q <= sp_wdata;
            if (take) begin
              pc_sv   <= cur_pc;
              num_sv  <= irq_num;
              prio_sv <= irq_prio;
              st      <= S_PUSH_PC;
            end
          end
        end
        S_PUSH_PC: begin
          sp_q <= sp_dn;
          st   <= S_PUSH_SR;
        end
        S_PUSH_SR: begin
          sp_q               <= sp_dn;
          sr_q[PRIO_W-1:0]   <= prio_sv;
          st                 <= S_IDLE;
        end
        S_POP_SR: begin
          sr_q <= mem_rdata;
          sp_q <= sp_up;
          st   <= S_POP_PC;
        end
        S_POP_PC: st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);  // R2
  AST_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> busy);  // R7
  AST_PC_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (mem_we && mem_wdata == $past(cur_pc)));  // R4
  AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - SP_ONE));  // R4
  AST_PRIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> ##2 (sr[PRIO_W-1:0] == $past(irq_prio, 3)));  // R5
  AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reti_cmd) |=> (mem_re && !mem_we));  // R6
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));  // R10
  AST_TRAP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cmd |=> (trap_req && trap_num == $past(trap_cmd_num)));  // R9
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, nmi = 0, trap_c = 0, reti = 0, srw = 0, spw = 0;
  logic [3:0] num = 0, trap_cn = 0;
  logic [2:0] prio = 0;
  logic [15:0] srwd = 0, cpc = 16'h1000;
  logic [7:0] spwd = 0;
  logic irq_ack, trap_req, pc_set, busy, mem_we, mem_re;
  logic [3:0] trap_num;
  logic [15:0] pc_new, sr, mem_wdata, mem_rdata;
  logic [7:0] sp, mem_addr;
  logic [15:0] mem [256];

  int vecs = 0, errs = 0;
  int ph = 0, msp = 0, msr = 7, mpc = 0, mnum = 0, mprio = 0, mtr = 0, mtn = 0;
  int mstk [256];

  always #10 clk = ~clk;

  irq_entry_seq #(.DATA_W(16), .ADDR_W(8), .NUM_W(4), .PRIO_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_nmi(nmi), .irq_num(num),
    .irq_prio(prio), .irq_ack(irq_ack), .trap_cmd(trap_c), .trap_cmd_num(trap_cn),
    .trap_req(trap_req), .trap_num(trap_num), .reti_cmd(reti), .sr_wr(srw),
    .sr_wdata(srwd), .sp_wr(spw), .sp_wdata(spwd), .cur_pc(cpc), .pc_set(pc_set),
    .pc_new(pc_new), .sr(sr), .sp(sp), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  initial for (int i = 0; i < 256; i++) begin mem[i] = 0; mstk[i] = 0; end

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int acc;
    #1;
    acc = (ph == 0 && !reti && !srw && !spw && req && (nmi || prio > (msr & 7))) ? 1 : 0;
    chk("R2 R3 R7 irq_ack", irq_ack, acc);
    chk("R7 busy", busy, ph != 0);
    chk("R4 R10 mem_we", mem_we, ph == 1 || ph == 2);
    chk("R6 mem_re", mem_re, (ph == 0 && reti) || ph == 3);
    if (ph == 1 || ph == 2) chk("R4 push address", mem_addr, (msp - 1) & 255);
    if ((ph == 0 && reti) || ph == 3) chk("R6 pop address", mem_addr, msp);
    if (ph == 1) chk("R4 pc pushed", mem_wdata, mpc);
    if (ph == 2) chk("R4 status pushed", mem_wdata, msr);
    chk("R5 R6 pc_set", pc_set, ph == 2 || ph == 4);
    if (ph == 2) chk("R5 vector", pc_new, mnum);
    if (ph == 4) chk("R6 pc restored", pc_new, mstk[(msp - 1) & 255]);
    chk("R1 R5 R6 R8 status", sr, msr);
    chk("R1 R4 R6 R8 stack pointer", sp, msp);
    chk("R9 trap_req", trap_req, mtr);
    if (mtr != 0) chk("R9 trap_num", trap_num, mtn);
    @(posedge clk);
    mtr = trap_c; mtn = trap_cn;
    case (ph)
      0: if (reti) begin msp = (msp + 1) & 255; ph = 3; end
         else begin
           if (srw) msr = srwd;
           if (spw) msp = spwd;
           if (acc != 0) begin mpc = cpc; mnum = num; mprio = prio; ph = 1; end
         end
      1: begin mstk[(msp - 1) & 255] = mpc; msp = (msp - 1) & 255; ph = 2; end
      2: begin mstk[(msp - 1) & 255] = msr; msp = (msp - 1) & 255;
               msr = (msr & 16'hFFF8) | mprio; ph = 0; end
      3: begin msr = mstk[(msp - 1) & 255]; msp = (msp + 1) & 255; ph = 4; end
      default: ph = 0;
    endcase
    @(negedge clk);
    cpc = cpc + 16'd3;
  endtask

  task automatic offer(int n, int p, bit nm, int lim);
    req = 1; num = n[3:0]; prio = p[2:0]; nmi = nm;
    for (int i = 0; i < lim; i++) begin
      bit got;
      #1 got = irq_ack;
      step();
      if (got) break;
    end
    req = 0; nmi = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);                                  // R1 reset state
    offer(3, 7, 0, 4);                        // R1 blocked at max priority
    srw = 1; srwd = 16'h00A2; spw = 1; spwd = 8'h04;
    req = 1; prio = 6; num = 1;               // R8 writes block acceptance
    step();
    srw = 0; spw = 0; req = 0;
    offer(5, 2, 0, 3);                        // R2 equal priority refused
    offer(9, 5, 0, 3);                        // R2 strictly above taken
    srw = 1; srwd = 16'h0000; step(); srw = 0; // R8 ignored while busy
    offer(12, 1, 1, 6);                       // R3 NMI below runtime, R7 waits
    idle(1);
    offer(13, 6, 0, 4);                       // R4 stack wraps below zero
    trap_c = 1; trap_cn = 11; step();         // R9
    trap_c = 1; trap_cn = 4; step();
    trap_c = 0; idle(2);
    reti = 1; srw = 1; srwd = 16'h0007; step(); reti = 0; srw = 0; // R6 R8 return wins
    trap_c = 1; trap_cn = 9; step(); trap_c = 0;
    idle(2);
    reti = 1; req = 1; nmi = 1; num = 2; step(); reti = 0;         // R6 over request
    idle(1);
    offer(2, 0, 1, 4);                        // R3 held NMI taken after return
    idle(1);
    for (int k = 0; k < 3; k++) begin reti = 1; step(); reti = 0; idle(3); end
    offer(7, 3, 0, 3);
    offer(7, 4, 0, 3);
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule